// File: doc/BRIEF.md
# Iterative Integer Divide and Remainder Unit

This unit performs 64-bit integer division and returns either the quotient or the remainder. It supports signed and unsigned operation and has 32-bit word forms. A request carries a 3-bit operation code and two operands. It is accepted on a valid/ready handshake, and one result comes back with a single-cycle valid pulse. There is no backpressure on the result side.

Division by zero and the one signed overflow case (most negative value divided by minus one) do not raise an exception. Each has a fixed result. These cases are detected as the request is accepted, and their results are returned on the next cycle. All other requests go through a radix-2 restoring iteration: 64 steps for full-width forms and 32 steps for word forms. A final cycle then applies the sign and produces the result.

The word forms use only the low 32 bits of each operand. Their 32-bit result is always sign-extended to 64 bits, including for the unsigned word forms.

Top module: `int_div_unit`

## Requirements
- R1: `op_i` bit 0 selects the remainder (1) or the quotient (0). Bit 1 selects unsigned (1) or signed (0). Bit 2 selects the word form (1) or full width (0). Quotients truncate toward zero.
- R2: A nonzero signed remainder takes the sign of the dividend. For every non-special request, dividend = quotient × divisor + remainder, and |remainder| < |divisor|.
- R3: A quotient with a zero divisor is all ones (64 bits), for signed, unsigned and both word forms.
- R4: A remainder with a zero divisor returns the dividend. Full-width forms return all 64 bits unchanged. Word forms return the dividend's low 32 bits, sign-extended.
- R5: Signed overflow gives the minimum value as the quotient and 0 as the remainder. At full width the dividend is 0x8000000000000000 and the divisor is all ones. In word form the low words are 0x80000000 and 0xFFFFFFFF, and the quotient is 0xFFFFFFFF80000000.
- R6: Word forms ignore bits 63:32 of both operands.
- R7: Every word-form result has bits 63:32 equal to bit 31.
- R8: A zero-divisor or overflow request raises `out_valid_o` at the accepting clock edge. The result is therefore present in the very next cycle.
- R9: Any other request raises `out_valid_o` 65 clock edges after the accepting edge for full-width forms, and 33 edges after it for word forms.
- R10: `in_ready_o` stays low from the acceptance of an iterating request until its result is presented. Requests offered meanwhile are neither accepted nor able to change the result.
- R11: After reset, `out_valid_o` is low and `in_ready_o` is high. Each accepted request produces exactly one single-cycle `out_valid_o` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Request valid |
| in_ready_o | output | 1 | Unit can accept a request |
| op_i | input | 3 | {word, unsigned, remainder} |
| opa_i | input | 64 | Dividend |
| opb_i | input | 64 | Divisor |
| out_valid_o | output | 1 | One-cycle result strobe |
| out_data_o | output | 64 | Quotient or remainder |

## Verification
The assertions assume the operation code and operands are stable only in the accepting cycle. They also assume nobody expects the result to be held beyond the valid pulse. The bench changes operands freely in other cycles, keeps `in_valid_i` asserted while the unit is busy, and reads each result only in its valid cycle. The remainder-bound property assumes a nonzero divisor reaches the iteration core. The stimulus includes zero divisors, and the property relies on the unit diverting those before iteration. The bench compares results against an arithmetic model for all eight operations, over directed sign patterns and random operands.

// File: rtl/div_pkg.sv
package div_pkg;
  localparam int OP_REM  = 0;
  localparam int OP_UNS  = 1;
  localparam int OP_WORD = 2;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUSY = 2'd1,
    ST_FIN  = 2'd2
  } div_state_e;
endpackage

// File: rtl/div_prep.sv
module div_prep import div_pkg::*; #(
  parameter int W = 64
) (
  input  logic [2:0]   op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] dvd_o,
  output logic [W-1:0] dvs_o,
  output logic         neg_q_o,
  output logic         neg_r_o,
  output logic         special_o,
  output logic [W-1:0] spec_res_o
);
  localparam int HW = W / 2;

  logic [W-1:0] a_x, b_x, mag_a, min_x;
  logic         sa, sb, b_zero, ovf;

  // operand conditioning for word forms
  always_comb begin
    if (op_i[OP_WORD]) begin
      a_x = op_i[OP_UNS] ? {{HW{1'b0}}, a_i[HW-1:0]} : {{HW{a_i[HW-1]}}, a_i[HW-1:0]};
      b_x = op_i[OP_UNS] ? {{HW{1'b0}}, b_i[HW-1:0]} : {{HW{b_i[HW-1]}}, b_i[HW-1:0]};
      min_x = {{(HW+1){1'b1}}, {(HW-1){1'b0}}};
    end else begin
      a_x = a_i;
      b_x = b_i;
      min_x = {1'b1, {(W-1){1'b0}}};
    end
  end

  assign sa     = ~op_i[OP_UNS] & a_x[W-1];
  assign sb     = ~op_i[OP_UNS] & b_x[W-1];
  assign mag_a  = sa ? -a_x : a_x;
  assign dvs_o  = sb ? -b_x : b_x;
  // word forms preload the magnitude in the upper half so HW steps suffice
  assign dvd_o  = op_i[OP_WORD] ? (mag_a << HW) : mag_a;
  assign neg_q_o = sa ^ sb;
  assign neg_r_o = sa;

  assign b_zero    = (b_x == '0);
  assign ovf       = ~op_i[OP_UNS] & (a_x == min_x) & (b_x == '1);
  assign special_o = b_zero | ovf;

  always_comb begin
    if (b_zero)      spec_res_o = op_i[OP_REM] ? a_x : '1;
    else             spec_res_o = op_i[OP_REM] ? '0  : a_x;
  end
endmodule

// File: rtl/div_iter.sv
module div_iter #(
  parameter int W = 64
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         step_i,
  input  logic [W-1:0] dvd_i,
  input  logic [W-1:0] dvs_i,
  output logic [W-1:0] quo_o,
  output logic [W-1:0] rem_o
);
  logic [W-1:0] q_q, d_q;
  logic [W:0]   r_q, shifted;
  logic [W+1:0] diff;

  assign shifted = {r_q[W-1:0], q_q[W-1]};
  assign diff    = {1'b0, shifted} - {2'b00, d_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_q <= '0;
      r_q <= '0;
      d_q <= '0;
    end else if (load_i) begin
      q_q <= dvd_i;
      r_q <= '0;
      d_q <= dvs_i;
    end else if (step_i) begin
      if (!diff[W+1]) begin
        r_q <= diff[W:0];
        q_q <= {q_q[W-2:0], 1'b1};
      end else begin
        r_q <= shifted;
        q_q <= {q_q[W-2:0], 1'b0};
      end
    end
  end

  assign quo_o = q_q;
  assign rem_o = r_q[W-1:0];

  AST_REM_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(step_i) && !$past(load_i) |-> r_q < {1'b0, d_q}); // R2
endmodule

// File: rtl/int_div_unit.sv
module int_div_unit import div_pkg::*; #(
  parameter int W = 64
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         in_valid_i,
  output logic         in_ready_o,
  input  logic [2:0]   op_i,
  input  logic [W-1:0] opa_i,
  input  logic [W-1:0] opb_i,
  output logic         out_valid_o,
  output logic [W-1:0] out_data_o
);
  localparam int HW = W / 2;
  localparam int CW = $clog2(W + 1);

  div_state_e   state_q;
  logic [CW-1:0] cnt_q;
  logic [2:0]   op_q;
  logic         neg_q_q, neg_r_q;
  logic         fire, special, neg_q, neg_r, load, step;
  logic [W-1:0] dvd, dvs, spec_res, quo, rem, res_raw, res_sgn;

  assign in_ready_o = (state_q == ST_IDLE);
  assign fire = in_valid_i & in_ready_o;
  assign load = fire & ~special;
  assign step = (state_q == ST_BUSY);

  div_prep #(.W(W)) u_prep (
    .op_i(op_i), .a_i(opa_i), .b_i(opb_i),
    .dvd_o(dvd), .dvs_o(dvs), .neg_q_o(neg_q), .neg_r_o(neg_r),
    .special_o(special), .spec_res_o(spec_res)
  );

  div_iter #(.W(W)) u_iter (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load), .step_i(step),
    .dvd_i(dvd), .dvs_i(dvs), .quo_o(quo), .rem_o(rem)
  );

  function automatic logic [W-1:0] fit(input logic word, input logic [W-1:0] x);
    return word ? {{HW{x[HW-1]}}, x[HW-1:0]} : x;
  endfunction

  assign res_raw = op_q[OP_REM] ? rem : quo;
  assign res_sgn = (op_q[OP_REM] ? neg_r_q : neg_q_q) ? -res_raw : res_raw;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      cnt_q       <= '0;
      op_q        <= '0;
      neg_q_q     <= 1'b0;
      neg_r_q     <= 1'b0;
      out_valid_o <= 1'b0;
      out_data_o  <= '0;
    end else begin
      out_valid_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (fire) begin
          op_q    <= op_i;
          neg_q_q <= neg_q;
          neg_r_q <= neg_r;
          if (special) begin
            out_valid_o <= 1'b1;
            out_data_o  <= fit(op_i[OP_WORD], spec_res);
          end else begin
            cnt_q   <= op_i[OP_WORD] ? CW'(HW) : CW'(W);
            state_q <= ST_BUSY;
          end
        end
        ST_BUSY: begin
          cnt_q <= cnt_q - 1'b1;
          if (cnt_q == CW'(1)) state_q <= ST_FIN;
        end
        ST_FIN: begin
          out_valid_o <= 1'b1;
          out_data_o  <= fit(op_q[OP_WORD], res_sgn);
          state_q     <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_DIV0_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire && !op_i[OP_REM] && (op_i[OP_WORD] ? opb_i[HW-1:0] == '0 : opb_i == '0)
    |=> out_valid_o && out_data_o == '1); // R3
  AST_REM0_DVD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire && op_i[OP_REM] && !op_i[OP_WORD] && opb_i == '0
    |=> out_data_o == $past(opa_i)); // R4
  AST_SPECIAL_FAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire && special |=> out_valid_o); // R8
  AST_BUSY_NOT_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire && !special |=> !in_ready_o && !out_valid_o); // R10
  AST_WORD_SEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && op_q[OP_WORD] |-> out_data_o[W-1:HW] == {HW{out_data_o[HW-1]}}); // R7
  AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |=> !out_valid_o); // R11
endmodule

// File: tb/int_div_unit_tb.sv
`timescale 1ns/1ps
module int_div_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [2:0]  op = '0;
  logic [63:0] opa = '0, opb = '0;
  logic        out_valid;
  logic [63:0] out_data;
  int          n_checks = 0;
  int          n_errors = 0;

  always #2 clk = ~clk;

  int_div_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .op_i(op), .opa_i(opa), .opb_i(opb),
    .out_valid_o(out_valid), .out_data_o(out_data)
  );

  localparam logic [63:0] MIN64 = 64'h8000_0000_0000_0000;

  function automatic logic [63:0] model(input logic [2:0] o, input logic [63:0] a, input logic [63:0] b);
    logic [31:0] r32;
    if (!o[2]) begin
      if (b == 0) return o[0] ? a : '1;
      if (!o[1] && a == MIN64 && b == '1) return o[0] ? 64'd0 : MIN64;
      if (o[1]) return o[0] ? a % b : a / b;
      return o[0] ? 64'($signed(a) % $signed(b)) : 64'($signed(a) / $signed(b));
    end
    if (b[31:0] == 0) r32 = o[0] ? a[31:0] : '1;
    else if (!o[1] && a[31:0] == 32'h8000_0000 && b[31:0] == '1) r32 = o[0] ? 32'd0 : 32'h8000_0000;
    else if (o[1]) r32 = o[0] ? a[31:0] % b[31:0] : a[31:0] / b[31:0];
    else r32 = o[0] ? 32'($signed(a[31:0]) % $signed(b[31:0])) : 32'($signed(a[31:0]) / $signed(b[31:0]));
    return {{32{r32[31]}}, r32};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic [2:0] o, input logic [63:0] a, input logic [63:0] b,
                        output logic [63:0] res, output int lat);
    @(negedge clk);
    op = o; opa = a; opb = b; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    opa = ~a; opb = ~b;
    lat = 1;
    while (!out_valid && lat < 200) begin
      @(negedge clk);
      lat++;
    end
    res = out_data;
  endtask

  task automatic t_reset;
    chk("R11 reset out_valid", 64'(out_valid), 64'd0);
    chk("R11 reset in_ready", 64'(in_ready), 64'd1);
  endtask

  task automatic t_directed;
    logic [63:0] pa [10];
    logic [63:0] pb [10];
    logic [63:0] res;
    int lat;
    pa = '{64'd100, -64'sd100, 64'd100, -64'sd100, 64'd7, 64'h7FFF_FFFF_FFFF_FFFF,
           MIN64, 64'h1234_5678_9ABC_DEF0, 64'd1, 64'hDEAD_BEEF_CAFE_BABE};
    pb = '{64'd7, 64'd7, -64'sd7, -64'sd7, 64'd100, 64'd3,
           64'd1, 64'h1234, 64'd1, 64'hFFFF_FFFF_0000_0001};
    for (int i = 0; i < 10; i++)
      for (int o = 0; o < 8; o++) begin
        run_op(3'(o), pa[i], pb[i], res, lat);
        chk($sformatf("R1 R2 R7 op%0d pair%0d", o, i), res, model(3'(o), pa[i], pb[i]));
      end
  endtask

  task automatic t_div_zero;
    logic [63:0] res;
    int lat;
    run_op(3'd0, 64'd55, 64'd0, res, lat);         chk("R3 signed div0", res, '1);
    run_op(3'd2, 64'd55, 64'd0, res, lat);         chk("R3 unsigned div0", res, '1);
    run_op(3'd4, -64'sd9, 64'hFFFF_0000_0000_0000, res, lat); chk("R3 word div0", res, '1);
    run_op(3'd6, 64'd9, 64'd0, res, lat);          chk("R3 word unsigned div0", res, '1);
    run_op(3'd1, 64'hF00D_0000_0000_0042, 64'd0, res, lat); chk("R4 rem0", res, 64'hF00D_0000_0000_0042);
    run_op(3'd3, 64'h8000_0000_0000_0001, 64'd0, res, lat); chk("R4 remu0", res, 64'h8000_0000_0000_0001);
    run_op(3'd5, 64'h1111_2222_8000_0005, 64'd0, res, lat); chk("R4 remw0", res, 64'hFFFF_FFFF_8000_0005);
    run_op(3'd7, 64'h1111_2222_9000_0005, 64'd0, res, lat); chk("R4 remuw0", res, 64'hFFFF_FFFF_9000_0005);
    run_op(3'd7, 64'h1111_2222_7000_0005, 64'd0, res, lat); chk("R4 remuw0 positive", res, 64'h0000_0000_7000_0005);
  endtask

  task automatic t_overflow;
    logic [63:0] res;
    int lat;
    run_op(3'd0, MIN64, '1, res, lat); chk("R5 div overflow", res, MIN64);
    run_op(3'd1, MIN64, '1, res, lat); chk("R5 rem overflow", res, 64'd0);
    run_op(3'd4, 64'h0000_0001_8000_0000, 64'h0000_0000_FFFF_FFFF, res, lat);
    chk("R5 divw overflow", res, 64'hFFFF_FFFF_8000_0000);
    run_op(3'd5, 64'h0000_0001_8000_0000, 64'h0000_0000_FFFF_FFFF, res, lat);
    chk("R5 remw overflow", res, 64'd0);
    run_op(3'd2, MIN64, '1, res, lat); chk("R5 divu not overflow", res, 64'd0);
  endtask

  task automatic t_word_upper;
    logic [63:0] res;
    int lat;
    run_op(3'd4, 64'hAAAA_0000_0000_0064, 64'h5555_1234_FFFF_FFF9, res, lat);
    chk("R6 divw upper ignored", res, -64'sd14);
    run_op(3'd7, 64'hFFFF_FFFF_0000_0064, 64'h0123_4567_0000_0007, res, lat);
    chk("R6 remuw upper ignored", res, 64'd2);
    run_op(3'd6, 64'h0000_0000_FFFF_FFFF, 64'hFFFF_FFFF_0000_0001, res, lat);
    chk("R7 divuw sign extends", res, '1);
  endtask

  task automatic t_latency;
    logic [63:0] res;
    int lat;
    run_op(3'd0, 64'd1000, 64'd3, res, lat); chk("R9 full latency", 64'(lat - 1), 64'd65);
    run_op(3'd5, 64'd1000, 64'd3, res, lat); chk("R9 word latency", 64'(lat - 1), 64'd33);
    run_op(3'd2, 64'd1000, 64'd0, res, lat); chk("R8 div0 latency", 64'(lat), 64'd1);
    run_op(3'd0, MIN64, '1, res, lat);       chk("R8 overflow latency", 64'(lat), 64'd1);
  endtask

  task automatic t_busy;
    int low = 0;
    int pulses = 0;
    @(negedge clk);
    op = 3'd0; opa = 64'd999; opb = 64'd10; in_valid = 1'b1;
    @(negedge clk);
    op = 3'd3; opa = 64'd5; opb = 64'd0;
    for (int i = 0; i < 10; i++) begin
      if (!in_ready) low++;
      @(negedge clk);
    end
    in_valid = 1'b0;
    chk("R10 in_ready low while busy", 64'(low), 64'd10);
    for (int i = 0; i < 100 && !out_valid; i++) @(negedge clk);
    chk("R10 result of first request", out_data, 64'd99);
    chk("R10 ready with result", 64'(in_ready), 64'd1);
    @(negedge clk);
    for (int i = 0; i < 80; i++) begin
      if (out_valid) pulses++;
      @(negedge clk);
    end
    chk("R11 no extra pulse", 64'(pulses), 64'd0);
  endtask

  task automatic t_random;
    logic [63:0] res, a, b;
    int lat;
    for (int i = 0; i < 160; i++) begin
      a = {$urandom, $urandom};
      b = {$urandom, $urandom};
      if (i % 4 == 1) b = b >> (i % 60);
      if (i % 4 == 2) b = 64'($signed(b) >>> (i % 60));
      run_op(3'(i % 8), a, b, res, lat);
      chk($sformatf("R1 R2 random op%0d", i % 8), res, model(3'(i % 8), a, b));
    end
  endtask

  initial begin
    #600000;
    n_errors++;
    n_checks++;
    $display("FAIL R9 watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_directed();
    t_div_zero();
    t_overflow();
    t_word_upper();
    t_latency();
    t_busy();
    t_random();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule